// File: doc/BRIEF.md
# Pixel Row Readout Sequencer

This controller drives the row select, reset and transfer-gate lines of a rolling-readout array of four-transistor pinned-photodiode pixels. It also gives start and stop strobes to the column oversampling converters. A one-cycle `start` pulse begins a frame.

In imaging mode the frame visits every row once, in ascending order. In each row the block holds the selected row in reset, then releases reset. It converts the reset level, pulses the transfer gate and converts the signal level over a window of the same length. The row ends with a flush in which reset and transfer gate are on together.

In thermal mode the block selects every row at once and keeps reset on. The transfer gate stays off. The block runs one conversion for each of the four rotation phases of the bias-current matching sequence. It reports the current phase on `dem_phase`.

Two rules hold in both modes. Mode and oversampling ratio are sampled only when a frame starts. A one-cycle guard, in which no control line moves, always comes before a conversion window.

Top module: `pix_readout_seq`

## Requirements
- R1: After reset, and whenever no frame is running, `row_sel`, `rst_line`, `tg_line`, `conv_start`, `conv_stop`, `frame_start` and `done` are 0 and `row_index` is 0.
- R2: Each imaging row opens with its select line high and `rst_line` high for SEL_CYC cycles. One guard cycle follows with reset low, and then the first conversion window starts. The row select, reset, transfer gate and phase outputs never change in the cycle that carries `conv_start`.
- R3: A conversion window lasts exactly OSR_EFF cycles. `conv_start` is high in its first cycle and `conv_stop` in its last. OSR_EFF is `osr_in`, or OSR_MIN when `osr_in` is below OSR_MIN.
- R4: After the first window, `tg_line` is high for TG_CYC cycles. One guard cycle follows, then the second window, of the same length as the first. The transfer gate is low whenever a strobe is high.
- R5: Each row ends with `rst_line` and `tg_line` both high for FLUSH_CYC cycles while the row stays selected. The next row starts in the following cycle, so a row period is SEL_CYC+TG_CYC+FLUSH_CYC+2+2·OSR_EFF cycles.
- R6: An imaging frame runs ROWS row periods with `row_index` counting 0 to ROWS-1. `row_sel` is one-hot, with bit `row_index` set, for the whole of each row period.
- R7: `frame_start` is high for exactly the first cycle of a frame. `done` is high for exactly one cycle, the cycle after the frame's last cycle, and every line is low in that cycle.
- R8: In thermal mode (`mode_thermal`=1 at start), all bits of `row_sel` and `rst_line` are high for the whole frame and `tg_line` is never high.
- R9: A thermal frame runs 4 phases, with `dem_phase` counting 0 to 3. Each phase is one guard cycle followed by one conversion window, so the frame lasts 4·(1+OSR_EFF) cycles.
- R10: `mode_thermal` and `osr_in` are sampled only on the cycle that `start` is accepted while idle. Changes to either, and `start` pulses, during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| mode_thermal | input | 1 | 1 selects thermal mode for the next frame |
| osr_in | input | OSR_W | Oversampling ratio for the next frame |
| row_sel | output | ROWS | Row select lines |
| rst_line | output | 1 | Pixel reset line |
| tg_line | output | 1 | Transfer gate line |
| conv_start | output | 1 | Converter window start strobe |
| conv_stop | output | 1 | Converter window stop strobe |
| frame_start | output | 1 | High in the first cycle of a frame |
| done | output | 1 | One-cycle end-of-frame pulse |
| row_index | output | ROW_W | Row being read out |
| dem_phase | output | 2 | Current matching phase in thermal mode |

## Verification
The bench builds the sequencer with ROWS=6, SEL_CYC=2, TG_CYC=3, FLUSH_CYC=2 and OSR_MIN=4. With these values full frames are short, so every strobe of several whole frames can be checked against an exact cycle count. Ratios of 5, 1023 (the largest the 10-bit field holds) and 2 are run. The ratio of 2 exercises the clamp to the minimum. Mid-frame changes of mode, ratio and extra start pulses are applied to show that a frame keeps the settings it started with.

// File: rtl/pix_seq_pkg.sv
package pix_seq_pkg;

    localparam int DEM_PHASES = 4;
    localparam int DEM_W      = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_GRD1,
        ST_CNV1,
        ST_TG,
        ST_GRD2,
        ST_CNV2,
        ST_FLUSH,
        ST_TGRD,
        ST_TCNV
    } seq_state_e;

    typedef struct packed {
        logic sel_one;
        logic sel_all;
        logic rst;
        logic tg;
        logic cstart;
        logic cstop;
    } line_ctl_t;

    function automatic int clamp_low(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/pix_seq_timer.sv
module pix_seq_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else              count <= count + 1'b1;
    end

    assign last = (count == limit);
endmodule

// File: rtl/pix_seq_cfg.sv
module pix_seq_cfg
    import pix_seq_pkg::*;
#(
    parameter int OSR_W   = 10,
    parameter int OSR_MIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             mode_in,
    input  logic [OSR_W-1:0] osr_in,
    output logic             thermal,
    output logic [OSR_W-1:0] osr_eff
);
    logic [OSR_W-1:0] osr_next;

    always_comb begin
        osr_next = OSR_W'(clamp_low(int'(osr_in), OSR_MIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thermal <= 1'b0;
            osr_eff <= OSR_W'(OSR_MIN);
        end else if (load) begin
            thermal <= mode_in;
            osr_eff <= osr_next;
        end
    end
endmodule

// File: rtl/pix_row_decode.sv
module pix_row_decode #(
    parameter int ROWS  = 64,
    parameter int ROW_W = 6
) (
    input  logic             sel_one,
    input  logic             sel_all,
    input  logic [ROW_W-1:0] row_idx,
    output logic [ROWS-1:0]  row_sel
);
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign row_sel[i] = sel_all | (sel_one & (row_idx == ROW_W'(i)));
    end
endmodule

// File: rtl/pix_seq_ctrl.sv
module pix_seq_ctrl
    import pix_seq_pkg::*;
#(
    parameter int ROWS      = 64,
    parameter int ROW_W     = 6,
    parameter int OSR_W     = 10,
    parameter int SEL_CYC   = 2,
    parameter int TG_CYC    = 4,
    parameter int FLUSH_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_thermal,
    input  logic [OSR_W-1:0] osr_eff,
    input  logic [OSR_W-1:0] tm_count,
    input  logic             tm_last,
    output logic             tm_clear,
    output logic [OSR_W-1:0] tm_limit,
    output logic             load_cfg,
    output line_ctl_t        ctl,
    output logic [ROW_W-1:0] row_idx,
    output logic [DEM_W-1:0] phase,
    output logic             frame_start,
    output logic             done
);
    localparam logic [ROW_W-1:0] LAST_ROW   = ROW_W'(ROWS - 1);
    localparam logic [DEM_W-1:0] LAST_PHASE = DEM_W'(DEM_PHASES - 1);

    seq_state_e state, state_nx;
    logic       adv;
    logic       finish;
    logic       win_first;

    assign load_cfg  = (state == ST_IDLE) && start;
    assign adv       = (state != ST_IDLE) && tm_last;
    assign tm_clear  = load_cfg || adv || (state == ST_IDLE);
    assign win_first = (tm_count == '0);

    always_comb begin
        case (state)
            ST_SEL:   tm_limit = OSR_W'(SEL_CYC - 1);
            ST_TG:    tm_limit = OSR_W'(TG_CYC - 1);
            ST_FLUSH: tm_limit = OSR_W'(FLUSH_CYC - 1);
            ST_CNV1,
            ST_CNV2,
            ST_TCNV:  tm_limit = osr_eff - OSR_W'(1);
            default:  tm_limit = '0;
        endcase
    end

    always_comb begin
        state_nx = state;
        finish   = 1'b0;
        case (state)
            ST_IDLE:  if (start) state_nx = start_thermal ? ST_TGRD : ST_SEL;
            ST_SEL:   if (adv) state_nx = ST_GRD1;
            ST_GRD1:  if (adv) state_nx = ST_CNV1;
            ST_CNV1:  if (adv) state_nx = ST_TG;
            ST_TG:    if (adv) state_nx = ST_GRD2;
            ST_GRD2:  if (adv) state_nx = ST_CNV2;
            ST_CNV2:  if (adv) state_nx = ST_FLUSH;
            ST_FLUSH: begin
                if (adv) begin
                    if (row_idx == LAST_ROW) begin
                        state_nx = ST_IDLE;
                        finish   = 1'b1;
                    end else begin
                        state_nx = ST_SEL;
                    end
                end
            end
            ST_TGRD:  if (adv) state_nx = ST_TCNV;
            ST_TCNV: begin
                if (adv) begin
                    if (phase == LAST_PHASE) begin
                        state_nx = ST_IDLE;
                        finish   = 1'b1;
                    end else begin
                        state_nx = ST_TGRD;
                    end
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            row_idx     <= '0;
            phase       <= '0;
            frame_start <= 1'b0;
            done        <= 1'b0;
        end else begin
            state       <= state_nx;
            frame_start <= load_cfg;
            done        <= finish;
            if (load_cfg || finish) begin
                row_idx <= '0;
                phase   <= '0;
            end else if (adv && state == ST_FLUSH) begin
                row_idx <= row_idx + 1'b1;
            end else if (adv && state == ST_TCNV) begin
                phase <= phase + 1'b1;
            end
        end
    end

    always_comb begin
        ctl = '0;
        case (state)
            ST_SEL: begin
                ctl.sel_one = 1'b1;
                ctl.rst     = 1'b1;
            end
            ST_GRD1, ST_GRD2: ctl.sel_one = 1'b1;
            ST_CNV1, ST_CNV2: begin
                ctl.sel_one = 1'b1;
                ctl.cstart  = win_first;
                ctl.cstop   = tm_last;
            end
            ST_TG: begin
                ctl.sel_one = 1'b1;
                ctl.tg      = 1'b1;
            end
            ST_FLUSH: begin
                ctl.sel_one = 1'b1;
                ctl.rst     = 1'b1;
                ctl.tg      = 1'b1;
            end
            ST_TGRD: begin
                ctl.sel_all = 1'b1;
                ctl.rst     = 1'b1;
            end
            ST_TCNV: begin
                ctl.sel_all = 1'b1;
                ctl.rst     = 1'b1;
                ctl.cstart  = win_first;
                ctl.cstop   = tm_last;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/pix_readout_seq.sv
module pix_readout_seq
    import pix_seq_pkg::*;
#(
    parameter int ROWS      = 64,
    parameter int OSR_W     = 10,
    parameter int OSR_MIN   = 4,
    parameter int SEL_CYC   = 2,
    parameter int TG_CYC    = 4,
    parameter int FLUSH_CYC = 4,
    localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_thermal,
    input  logic [OSR_W-1:0] osr_in,
    output logic [ROWS-1:0]  row_sel,
    output logic             rst_line,
    output logic             tg_line,
    output logic             conv_start,
    output logic             conv_stop,
    output logic             frame_start,
    output logic             done,
    output logic [ROW_W-1:0] row_index,
    output logic [DEM_W-1:0] dem_phase
);
    logic             load_cfg;
    logic             cfg_thermal;
    logic [OSR_W-1:0] osr_eff;
    logic             tm_clear;
    logic [OSR_W-1:0] tm_limit;
    logic [OSR_W-1:0] tm_count;
    logic             tm_last;
    line_ctl_t        ctl;

    pix_seq_cfg #(.OSR_W(OSR_W), .OSR_MIN(OSR_MIN)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (load_cfg),
        .mode_in (mode_thermal),
        .osr_in  (osr_in),
        .thermal (cfg_thermal),
        .osr_eff (osr_eff)
    );

    pix_seq_timer #(.W(OSR_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tm_clear),
        .limit (tm_limit),
        .count (tm_count),
        .last  (tm_last)
    );

    pix_seq_ctrl #(
        .ROWS(ROWS), .ROW_W(ROW_W), .OSR_W(OSR_W),
        .SEL_CYC(SEL_CYC), .TG_CYC(TG_CYC), .FLUSH_CYC(FLUSH_CYC)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .start_thermal (mode_thermal),
        .osr_eff       (osr_eff),
        .tm_count      (tm_count),
        .tm_last       (tm_last),
        .tm_clear      (tm_clear),
        .tm_limit      (tm_limit),
        .load_cfg      (load_cfg),
        .ctl           (ctl),
        .row_idx       (row_index),
        .phase         (dem_phase),
        .frame_start   (frame_start),
        .done          (done)
    );

    pix_row_decode #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
        .sel_one (ctl.sel_one),
        .sel_all (ctl.sel_all),
        .row_idx (row_index),
        .row_sel (row_sel)
    );

    assign rst_line   = ctl.rst;
    assign tg_line    = ctl.tg;
    assign conv_start = ctl.cstart;
    assign conv_stop  = ctl.cstop;

    logic unused_cfg;
    assign unused_cfg = cfg_thermal;
endmodule

// File: rtl/pix_readout_seq_chk.sv
module pix_readout_seq_chk #(
    parameter int ROWS = 64
) (
    input logic            clk,
    input logic            rst,
    input logic [ROWS-1:0] row_sel,
    input logic            rst_line,
    input logic            tg_line,
    input logic            conv_start,
    input logic            conv_stop,
    input logic            done,
    input logic [1:0]      dem_phase
);
    p_guard_r2: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> ($stable(row_sel) && $stable(rst_line) && $stable(tg_line) && $stable(dem_phase)));

    p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> (!conv_start && !conv_stop));

    p_tg_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_start || conv_stop) |-> !tg_line);

    p_flush_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (rst_line && tg_line) |-> (row_sel != '0));

    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(row_sel) || (&row_sel)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (row_sel == '0 && !rst_line && !tg_line && !conv_start));

    p_thermal_tg_r8: assert property (@(posedge clk) disable iff (rst)
        (&row_sel) |-> (!tg_line && rst_line));
endmodule

bind pix_readout_seq pix_readout_seq_chk #(.ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .row_sel    (row_sel),
    .rst_line   (rst_line),
    .tg_line    (tg_line),
    .conv_start (conv_start),
    .conv_stop  (conv_stop),
    .done       (done),
    .dem_phase  (dem_phase)
);

// File: tb/pix_readout_seq_tb_top.sv
module pix_readout_seq_tb_top;
    localparam int ROWS  = 6;
    localparam int OSR_W = 10;
    localparam int OMIN  = 4;
    localparam int S     = 2;
    localparam int T     = 3;
    localparam int F     = 2;
    localparam int ROW_W = $clog2(ROWS);
    localparam int WD_LIMIT = 40000;

    typedef struct {
        int kind;
        int tag;
        int cyc;
    } ev_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             mode_thermal = 1'b0;
    logic [OSR_W-1:0] osr_in = '0;
    logic [ROWS-1:0]  row_sel;
    logic             rst_line, tg_line, conv_start, conv_stop;
    logic             frame_start, done;
    logic [ROW_W-1:0] row_index;
    logic [1:0]       dem_phase;

    always #5 clk = ~clk;

    pix_readout_seq #(
        .ROWS(ROWS), .OSR_W(OSR_W), .OSR_MIN(OMIN),
        .SEL_CYC(S), .TG_CYC(T), .FLUSH_CYC(F)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .mode_thermal(mode_thermal),
        .osr_in(osr_in), .row_sel(row_sel), .rst_line(rst_line),
        .tg_line(tg_line), .conv_start(conv_start), .conv_stop(conv_stop),
        .frame_start(frame_start), .done(done), .row_index(row_index),
        .dem_phase(dem_phase)
    );

    int checks = 0;
    int errors = 0;
    ev_t exp_q[$];

    int  fc = 0;
    bit  cur_thermal = 1'b0;
    bit  got_done = 1'b0;
    int  done_fc = 0;
    int  fs_cnt = 0, done_cnt = 0;
    int  sel_cnt = 0, all_cnt = 0, tg_cnt = 0, rst_cnt = 0, flush_cnt = 0;
    int  oh_bad = 0;
    int  ev_bad = 0;
    int  stray = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_start) begin
                fc = 0;
                fs_cnt++;
                sel_cnt = 0; all_cnt = 0; tg_cnt = 0; rst_cnt = 0; flush_cnt = 0;
                oh_bad = 0;
            end else begin
                fc++;
            end
            if (row_sel != '0) sel_cnt++;
            if (&row_sel) all_cnt++;
            if (tg_line) tg_cnt++;
            if (rst_line) rst_cnt++;
            if (rst_line && tg_line) flush_cnt++;
            if (!cur_thermal && row_sel != '0 && row_sel != (ROWS'(1) << row_index)) oh_bad++;
            if (conv_start || conv_stop) begin
                ev_t got;
                got.kind = conv_start ? 0 : 1;
                got.tag  = cur_thermal ? int'(dem_phase) : int'(row_index);
                got.cyc  = fc;
                if (exp_q.size() == 0) begin
                    stray++;
                    check(1'b0, "R3", "unexpected strobe at cycle", fc, -1);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(got.kind == e.kind && got.tag == e.tag && got.cyc == e.cyc,
                          cur_thermal ? "R9" : "R3", "strobe kind*1e6+tag*1e4+cycle",
                          got.kind*1000000 + got.tag*10000 + got.cyc,
                          e.kind*1000000 + e.tag*10000 + e.cyc);
                end
            end
            if (done) begin
                done_cnt++;
                done_fc  = fc;
                got_done = 1'b1;
            end
        end
    end

    task automatic push_ev(input int k, input int tg, input int c);
        ev_t e;
        e.kind = k; e.tag = tg; e.cyc = c;
        exp_q.push_back(e);
    endtask

    task automatic run_frame(input bit therm, input int osr, input bit disturb, output bit hung);
        int o, p, q, wd;
        o = (osr < OMIN) ? OMIN : osr;
        p = S + T + F + 2 + 2*o;
        q = 1 + o;
        hung = 1'b0;
        if (!therm) begin
            for (int r = 0; r < ROWS; r++) begin
                int b;
                b = r*p;
                push_ev(0, r, b+S+1);
                push_ev(1, r, b+S+o);
                push_ev(0, r, b+S+o+T+2);
                push_ev(1, r, b+S+2*o+T+1);
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                push_ev(0, k, k*q+1);
                push_ev(1, k, k*q+o);
            end
        end
        cur_thermal = therm;
        got_done = 1'b0;
        fs_cnt = 0;
        done_cnt = 0;
        @(negedge clk);
        mode_thermal = therm;
        osr_in = OSR_W'(osr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10: flip the mode, change the ratio and request again mid-frame
            mode_thermal = ~therm;
            osr_in = OSR_W'(o + 3);
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!got_done && wd < WD_LIMIT) begin
            @(posedge clk);
            wd++;
        end
        if (!got_done) begin
            hung = 1'b1;
            check(1'b0, "R7", "watchdog expired waiting for done", wd, WD_LIMIT);
            return;
        end
        repeat (3) @(negedge clk);
        check(fs_cnt == 1, "R7", "frame_start pulses", fs_cnt, 1);
        check(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
        check(exp_q.size() == 0, therm ? "R9" : "R3", "strobes left unseen", exp_q.size(), 0);
        exp_q.delete();
        if (!therm) begin
            check(done_fc == ROWS*p, "R5", "done cycle in imaging frame", done_fc, ROWS*p);
            check(sel_cnt == ROWS*p, "R6", "selected cycles", sel_cnt, ROWS*p);
            check(oh_bad == 0, "R6", "row_sel/row_index mismatches", oh_bad, 0);
            check(all_cnt == 0, "R6", "all-row cycles in imaging", all_cnt, 0);
            check(rst_cnt == ROWS*(S+F), "R2", "reset-high cycles", rst_cnt, ROWS*(S+F));
            check(tg_cnt == ROWS*(T+F), "R4", "transfer-high cycles", tg_cnt, ROWS*(T+F));
            check(flush_cnt == ROWS*F, "R5", "flush cycles", flush_cnt, ROWS*F);
        end else begin
            check(done_fc == 4*q, "R9", "done cycle in thermal frame", done_fc, 4*q);
            check(all_cnt == 4*q, "R8", "all-row cycles", all_cnt, 4*q);
            check(rst_cnt == 4*q, "R8", "reset-high cycles", rst_cnt, 4*q);
            check(tg_cnt == 0, "R8", "transfer-high cycles", tg_cnt, 0);
        end
        if (disturb) check(1'b1 && exp_q.size() == 0, "R10", "frame kept start settings", 0, 0);
        check(row_sel == '0 && !rst_line && !tg_line, "R1", "lines after frame",
              int'(row_sel) + int'(rst_line) + int'(tg_line), 0);
        mode_thermal = 1'b0;
        osr_in = '0;
    endtask

    initial begin
        bit hung;
        hung = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(row_sel == '0, "R1", "row_sel after reset", int'(row_sel), 0);
        check(!rst_line && !tg_line, "R1", "reset/transfer after reset",
              int'(rst_line) + int'(tg_line), 0);
        check(!conv_start && !conv_stop && !frame_start && !done, "R1", "strobes after reset",
              int'(conv_start) + int'(conv_stop) + int'(frame_start) + int'(done), 0);
        check(row_index == '0, "R1", "row_index after reset", int'(row_index), 0);

        run_frame(1'b0, 5, 1'b0, hung);
        if (!hung) run_frame(1'b1, 7, 1'b0, hung);
        if (!hung) run_frame(1'b0, 2, 1'b0, hung);
        if (!hung) run_frame(1'b0, 6, 1'b1, hung);
        if (!hung) run_frame(1'b1, 4, 1'b1, hung);
        if (!hung) run_frame(1'b0, 1023, 1'b0, hung);
        if (!hung) run_frame(1'b1, 0, 1'b0, hung);
        if (!hung) begin
            repeat (5) @(negedge clk);
            check(stray == 0, "R1", "strobes while idle", stray, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule